// File: doc/BRIEF.md
# Bus Request Phase Capture Unit

This block sits passively on a shared processor system bus whose signals are all active low. It opens a capture each time the address strobe is seen low while the bus reset is released. In that strobe clock it latches the address pins, the six request lines and the request parity pin. In the clock that follows it latches the same address pins again, because they then carry a second word of transaction information.

While the first word is taken, the block checks the two address parity pins against their halves of the address. It reports which half failed and gives a one-clock error pulse. It also decodes the two-bit memory address-space size field when the request type shows a memory access. All captured values come out as active-high logical values. A one-clock valid strobe marks the point where both words are present.

Separately, the block takes a snapshot of the address pins when the bus reset goes from low to high. It holds this snapshot as the power-on configuration word. The bits are left undecoded for the logic that consumes them.

Top module: `brq_capture`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `req_valid` and `par_err` are 0, and `req_addr`, `req_ext`, `req_type`, `req_rp`, `asz`, `asz_valid`, `par_fail` and `cfg_word` are all zero.
- R2: On a clock edge where `ads_n` is 0, `bus_reset_n` is 1 and no capture is already open, the block takes a first-word capture. After that edge, `req_addr` = ~`addr_n`, where bit i stands for address bit i+3. In the same way `req_type` = ~`req_n` and `req_rp` = ~`rp_n`.
- R3: On the next edge, `req_ext` takes ~`addr_n` and `req_valid` is 1 for exactly the one cycle after that edge. It is therefore high in the second cycle after the strobe edge.
- R4: A parity pin is correct when it is high with an even number of its covered pins low, and low with an odd number low. `ap_n[1]` covers `addr_n[46:24]` (address 49..27) and `ap_n[0]` covers `addr_n[23:0]` (address 26..3). On each first-word capture, `par_fail[1]` and `par_fail[0]` are set to 1 where the matching pin is incorrect. The result is held until the next capture.
- R5: `par_err` is 1 for exactly the one cycle after a first-word capture in which either parity pin was incorrect, and is 0 at all other times.
- R6: Let kind be the logical value of request lines 2..1 at the first-word capture. When kind is 01, 10 or 11, `asz_valid` = 1 and `asz` = logical request lines 4..3 (`asz[1]` = line 4). When kind is 00, `asz_valid` = 0 and `asz` = 00.
- R7: A strobe seen while `bus_reset_n` is 0 is ignored: no capture output changes and `req_valid` stays 0.
- R8: A strobe seen on the edge right after a first-word capture is taken as the second-word clock and does not start a new capture. `req_addr` keeps the first word and `req_valid` pulses only once.
- R9: On the first edge where `bus_reset_n` is 1 after being 0, and also on the first edge after `rst` falls, `cfg_word` takes ~`addr_n`. Otherwise it does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high block reset |
| bus_reset_n | input | 1 | Bus reset pin, active low |
| ads_n | input | 1 | Address strobe pin, active low |
| addr_n | input | 47 | Address pins for address bits 49..3, active low |
| req_n | input | 6 | Request lines, active low |
| ap_n | input | 2 | Address parity pins: [1] upper half, [0] lower half |
| rp_n | input | 1 | Request parity pin, active low |
| req_addr | output | 47 | First-clock address word, logical |
| req_ext | output | 47 | Second-clock information word, logical |
| req_type | output | 6 | First-clock request lines, logical |
| req_rp | output | 1 | Captured request parity, logical |
| asz | output | 2 | Decoded address-space size |
| asz_valid | output | 1 | Size field applies (memory access) |
| par_fail | output | 2 | Held per-half parity failure status |
| par_err | output | 1 | One-cycle parity error pulse |
| req_valid | output | 1 | One-cycle strobe: both words captured |
| cfg_word | output | 47 | Power-on configuration word, logical |

## Verification
The assertions assume that the bus never places a new strobe in the second-word clock of a capture. They also assume that the bus reset pin stays steady for at least two clocks around a release. The random stimulus keeps to this: after every transaction it returns the strobe high for at least one idle cycle, and it holds the bus reset level for several cycles around each edge. The one deliberate back-to-back strobe is a directed case that checks the second strobe is ignored.

// File: rtl/bus_req_pkg.sv
package bus_req_pkg;

    localparam int REQ_W    = 6;
    localparam int KIND_MSB = 2;
    localparam int KIND_LSB = 1;
    localparam int SIZE_MSB = 4;
    localparam int SIZE_LSB = 3;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef struct packed {
        logic       valid;
        logic [1:0] size;
    } asz_t;

    // Size field applies only when the request kind marks a memory access.
    function automatic asz_t decode_asz(input logic [REQ_W-1:0] req_l);
        asz_t r;
        r.valid = (req_l[KIND_MSB:KIND_LSB] != 2'b00);
        r.size  = r.valid ? req_l[SIZE_MSB:SIZE_LSB] : 2'b00;
        return r;
    endfunction

endpackage

// File: rtl/brq_parity_check.sv
module brq_parity_check #(
    parameter int ADDR_W = 47,
    parameter int LO_W   = 24
) (
    input  logic [ADDR_W-1:0] addr_n,
    input  logic [1:0]        ap_n,
    output logic [1:0]        fail
);
    localparam int HI_W = ADDR_W - LO_W;

    for (genvar s = 0; s < 2; s++) begin : g_slice
        localparam int W   = (s == 0) ? LO_W : HI_W;
        localparam int LSB = (s == 0) ? 0 : LO_W;
        logic [W-1:0] pins;
        logic         odd_low;
        assign pins    = addr_n[LSB +: W];
        // Low pins are logical ones; odd count of them needs a low parity pin.
        assign odd_low = ^(~pins);
        assign fail[s] = (ap_n[s] == odd_low);
    end

endmodule

// File: rtl/brq_phase_seq.sv
module brq_phase_seq
    import bus_req_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_reset_n,
    input  logic ads_n,
    output logic take_first,
    output logic take_second
);
    phase_e phase_q;

    assign take_first  = (phase_q == PH_IDLE) && !ads_n && bus_reset_n;
    assign take_second = (phase_q == PH_SECOND) && bus_reset_n;

    always_ff @(posedge clk) begin
        if (rst || !bus_reset_n) begin
            phase_q <= PH_IDLE;
        end else if (take_first) begin
            phase_q <= PH_SECOND;
        end else begin
            phase_q <= PH_IDLE;
        end
    end

endmodule

// File: rtl/brq_cfg_sampler.sv
module brq_cfg_sampler #(
    parameter int ADDR_W = 47
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset_n,
    input  logic [ADDR_W-1:0] addr_n,
    output logic [ADDR_W-1:0] cfg_word
);
    logic was_high_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            was_high_q <= 1'b0;
            cfg_word   <= '0;
        end else begin
            was_high_q <= bus_reset_n;
            if (bus_reset_n && !was_high_q) begin
                cfg_word <= ~addr_n;
            end
        end
    end

endmodule

// File: rtl/brq_capture.sv
module brq_capture
    import bus_req_pkg::*;
#(
    parameter int ADDR_W = 47,
    parameter int LO_W   = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset_n,
    input  logic              ads_n,
    input  logic [ADDR_W-1:0] addr_n,
    input  logic [REQ_W-1:0]  req_n,
    input  logic [1:0]        ap_n,
    input  logic              rp_n,
    output logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] req_ext,
    output logic [REQ_W-1:0]  req_type,
    output logic              req_rp,
    output logic [1:0]        asz,
    output logic              asz_valid,
    output logic [1:0]        par_fail,
    output logic              par_err,
    output logic              req_valid,
    output logic [ADDR_W-1:0] cfg_word
);
    logic       take_first;
    logic       take_second;
    logic [1:0] slice_fail;
    asz_t       asz_dec;

    brq_phase_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .bus_reset_n (bus_reset_n),
        .ads_n       (ads_n),
        .take_first  (take_first),
        .take_second (take_second)
    );

    brq_parity_check #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_par (
        .addr_n (addr_n),
        .ap_n   (ap_n),
        .fail   (slice_fail)
    );

    brq_cfg_sampler #(.ADDR_W(ADDR_W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .bus_reset_n (bus_reset_n),
        .addr_n      (addr_n),
        .cfg_word    (cfg_word)
    );

    assign asz_dec = decode_asz(~req_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_addr  <= '0;
            req_ext   <= '0;
            req_type  <= '0;
            req_rp    <= 1'b0;
            asz       <= 2'b00;
            asz_valid <= 1'b0;
            par_fail  <= 2'b00;
            par_err   <= 1'b0;
            req_valid <= 1'b0;
        end else begin
            par_err   <= take_first && (slice_fail != 2'b00);
            req_valid <= take_second;
            if (take_first) begin
                req_addr  <= ~addr_n;
                req_type  <= ~req_n;
                req_rp    <= ~rp_n;
                asz       <= asz_dec.size;
                asz_valid <= asz_dec.valid;
                par_fail  <= slice_fail;
            end
            if (take_second) begin
                req_ext <= ~addr_n;
            end
        end
    end

endmodule

// File: rtl/brq_capture_chk.sv
module brq_capture_chk
    import bus_req_pkg::*;
#(
    parameter int ADDR_W = 47
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_reset_n,
    input logic              ads_n,
    input logic [1:0]        asz,
    input logic              asz_valid,
    input logic [1:0]        par_fail,
    input logic              par_err,
    input logic              req_valid,
    input logic [ADDR_W-1:0] cfg_word
);
    assert_valid_after_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ($past(ads_n, 2) == 1'b0 && $past(bus_reset_n, 2)));

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);

    assert_err_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        par_err |=> !par_err);

    assert_err_has_status_R4: assert property (@(posedge clk) disable iff (rst)
        par_err |-> (par_fail != 2'b00 && $past(ads_n) == 1'b0));

    assert_size_cleared_R6: assert property (@(posedge clk) disable iff (rst)
        !asz_valid |-> (asz == 2'b00));

    assert_no_capture_in_reset_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_reset_n) |-> !par_err);

    assert_cfg_steady_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_reset_n) && $past(bus_reset_n, 2) && !$past(rst) && !$past(rst, 2))
        |-> $stable(cfg_word));

endmodule

bind brq_capture brq_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_reset_n (bus_reset_n),
    .ads_n       (ads_n),
    .asz         (asz),
    .asz_valid   (asz_valid),
    .par_fail    (par_fail),
    .par_err     (par_err),
    .req_valid   (req_valid),
    .cfg_word    (cfg_word)
);

// File: tb/test_brq_capture.sv
module test_brq_capture;
    localparam int AW = 47;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_reset_n;
    logic          ads_n;
    logic [AW-1:0] addr_n;
    logic [5:0]    req_n;
    logic [1:0]    ap_n;
    logic          rp_n;
    logic [AW-1:0] req_addr, req_ext, cfg_word;
    logic [5:0]    req_type;
    logic          req_rp, asz_valid, par_err, req_valid;
    logic [1:0]    asz, par_fail;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    brq_capture i_brq_capture (
        .clk(clk), .rst(rst), .bus_reset_n(bus_reset_n), .ads_n(ads_n),
        .addr_n(addr_n), .req_n(req_n), .ap_n(ap_n), .rp_n(rp_n),
        .req_addr(req_addr), .req_ext(req_ext), .req_type(req_type),
        .req_rp(req_rp), .asz(asz), .asz_valid(asz_valid),
        .par_fail(par_fail), .par_err(par_err), .req_valid(req_valid),
        .cfg_word(cfg_word)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Correct parity pin levels: bit1 upper half, bit0 lower half.
    function automatic logic [1:0] good_ap(input logic [AW-1:0] pins);
        int lo_cnt = 0;
        int hi_cnt = 0;
        for (int i = 0; i < AW; i++) begin
            if (pins[i] == 1'b0) begin
                if (i < 24) lo_cnt++;
                else hi_cnt++;
            end
        end
        return {(hi_cnt % 2) == 0, (lo_cnt % 2) == 0};
    endfunction

    function automatic logic [2:0] exp_size(input logic [5:0] pins);
        logic [5:0] l = ~pins;
        if (l[2:1] == 2'b00) return 3'b000;
        return {1'b1, l[4:3]};
    endfunction

    function automatic logic [AW-1:0] rnd_addr();
        return {$urandom(), $urandom()};
    endfunction

    // One transaction. flip selects parity pins to corrupt; dbl keeps the strobe low a second clock.
    task automatic txn(input logic [AW-1:0] a, input logic [AW-1:0] b, input logic [5:0] rq,
                       input logic [1:0] flip, input logic rp, input bit dbl);
        logic [2:0] sz = exp_size(rq);
        ads_n = 1'b0; addr_n = a; req_n = rq; ap_n = good_ap(a) ^ flip; rp_n = rp;
        @(posedge clk); @(negedge clk);
        ads_n = dbl ? 1'b0 : 1'b1; addr_n = b; ap_n = good_ap(b);
        chk("R2 addr", {17'd0, req_addr}, {17'd0, ~a});
        chk("R2 type", {58'd0, req_type}, {58'd0, ~rq});
        chk("R2 rp", {63'd0, req_rp}, {63'd0, ~rp});
        chk("R4 par_fail", {62'd0, par_fail}, {62'd0, flip});
        chk("R5 par_err", {63'd0, par_err}, {63'd0, flip != 2'b00});
        chk("R6 asz", {61'd0, asz_valid, asz}, {61'd0, sz});
        @(posedge clk); @(negedge clk);
        ads_n = 1'b1; addr_n = rnd_addr();
        chk("R3 valid", {63'd0, req_valid}, 64'd1);
        chk("R3 ext", {17'd0, req_ext}, {17'd0, ~b});
        chk("R5 pulse over", {63'd0, par_err}, 64'd0);
        @(posedge clk); @(negedge clk);
        chk("R3 valid one cycle", {63'd0, req_valid}, 64'd0);
        if (dbl) chk("R8 addr kept", {17'd0, req_addr}, {17'd0, ~a});
    endtask

    initial begin
        #800000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] c, a;
        void'($urandom(32'd1234));
        rst = 1'b1; bus_reset_n = 1'b0; ads_n = 1'b1; addr_n = '1; req_n = '1; ap_n = 2'b11; rp_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 valid", {63'd0, req_valid}, 64'd0);
        chk("R1 err", {63'd0, par_err}, 64'd0);
        chk("R1 addr", {17'd0, req_addr}, 64'd0);
        chk("R1 cfg", {17'd0, cfg_word}, 64'd0);
        chk("R1 status", {58'd0, par_fail, asz_valid, asz, req_rp}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {17'd0, req_ext}, 64'd0);
        // Release of bus reset: configuration word sampled.
        c = rnd_addr(); addr_n = c; bus_reset_n = 1'b1;
        @(posedge clk); @(negedge clk);
        addr_n = rnd_addr();
        chk("R9 cfg sampled", {17'd0, cfg_word}, {17'd0, ~c});
        repeat (2) @(negedge clk);
        // Directed: all pins high, correct parity, no memory kind.
        txn('1, '1, 6'b111111, 2'b00, 1'b1, 0);
        txn(rnd_addr(), rnd_addr(), 6'b111101, 2'b10, 1'b0, 0);
        txn(rnd_addr(), rnd_addr(), 6'b100011, 2'b01, 1'b1, 0);
        txn('0, rnd_addr(), 6'b000000, 2'b11, 1'b0, 0);
        // R8: strobe held into the second clock.
        txn(rnd_addr(), rnd_addr(), 6'b101011, 2'b00, 1'b1, 1);
        for (int n = 0; n < 40; n++) begin
            txn(rnd_addr(), rnd_addr(), 6'($urandom()), 2'($urandom()), 1'($urandom()), 0);
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end
        chk("R9 cfg held", {17'd0, cfg_word}, {17'd0, ~c});
        // R7: strobe under bus reset ignored.
        a = ~req_addr;
        bus_reset_n = 1'b0;
        repeat (2) @(negedge clk);
        ads_n = 1'b0; addr_n = rnd_addr(); req_n = 6'b000000; ap_n = ~good_ap(addr_n);
        @(posedge clk); @(negedge clk);
        ads_n = 1'b1;
        chk("R7 no err", {63'd0, par_err}, 64'd0);
        @(posedge clk); @(negedge clk);
        chk("R7 no valid", {63'd0, req_valid}, 64'd0);
        chk("R7 addr kept", {17'd0, req_addr}, {17'd0, ~a});
        chk("R9 cfg kept in reset", {17'd0, cfg_word}, {17'd0, ~c});
        // Second release takes a new configuration word.
        c = rnd_addr(); addr_n = c; bus_reset_n = 1'b1;
        @(posedge clk); @(negedge clk);
        addr_n = rnd_addr();
        @(posedge clk); @(negedge clk);
        chk("R9 cfg resampled", {17'd0, cfg_word}, {17'd0, ~c});
        txn(rnd_addr(), rnd_addr(), 6'b110101, 2'b00, 1'b0, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule